// File: doc/BRIEF.md
# Accumulator CPU Control Sequencer

This block is the hardwired control unit of a small 8-bit accumulator processor. It runs as a Moore state machine. Every instruction begins with a shared three-cycle fetch. The third fetch cycle samples the opcode and the zero flag, and the machine then walks an opcode-specific execute sequence before it returns to the first fetch state. Every strobe comes from the current state alone, so the datapath sees clean, registered-state-derived controls for a whole cycle.

The surrounding datapath owns the address register, program counter, data and temporary registers, the instruction register, accumulator and memory. The sequencer only tells the datapath which register loads or increments and which source drives the shared 8-bit bus. A 16-bit address is formed by the data register's high path and the temporary register together. The instruction-register value must already show the incoming opcode during the third fetch cycle. The zero flag must be valid in that same cycle.

Top module: `acc_ctl_top`

## Requirements
- R1: Reset (`rst_n`) is active low and synchronous. After any clock edge with `rst_n` low, the outputs show the first fetch cycle: `pc_to_bus` and `ar_ld` high, every other strobe low, and `alu_sel` zero. The first fetch cycle is also the state the machine sits in while reset is held.
- R2: The fetch runs in three cycles. Cycle 1 raises `pc_to_bus` and `ar_ld`. Cycle 2 raises `mem_rd`, `mem_to_bus`, `dr_ld` and `pc_inc`. Cycle 3 raises `ir_ld`, `pc_to_bus` and `ar_ld`.
- R3: Opcode 0x00 takes 4 cycles in total. Its fourth cycle has every strobe low.
- R4: Opcode 0x01 (load accumulator) takes 8 cycles. Its execute cycles are, in order:
  - cycle 4: `mem_rd`, `mem_to_bus`, `dr_ld`, `pc_inc`, `ar_inc`
  - cycle 5: `mem_rd`, `mem_to_bus`, `dr_ld`, `tr_ld`, `pc_inc`
  - cycle 6: `drh_to_bus`, `tr_to_bus`, `ar_ld`
  - cycle 7: `mem_rd`, `mem_to_bus`, `dr_ld`
  - cycle 8: `drl_to_bus`, `ac_ld`
- R5: Opcode 0x02 (store accumulator) takes 8 cycles. Cycles 4 to 6 match those of R4. Cycle 7 raises `ac_to_bus` and `dr_ld`. Cycle 8 raises `drl_to_bus`, `bus_to_mem` and `mem_wr`.
- R6: Opcode 0x06 (jump if zero) with the zero flag low takes 5 cycles. Cycles 4 and 5 each raise only `pc_inc`.
- R7: Opcode 0x06 with the zero flag high takes 6 cycles. Cycle 4 raises `mem_rd`, `mem_to_bus`, `dr_ld` and `ar_inc`. Cycle 5 raises `mem_rd`, `mem_to_bus`, `dr_ld` and `tr_ld`. Cycle 6 raises `drh_to_bus`, `tr_to_bus` and `pc_ld`.
- R8: Any opcode other than 0x01, 0x02 and 0x06 behaves exactly as 0x00.
- R9: In every cycle, at most one of `mem_to_bus`, `pc_to_bus`, `drl_to_bus`, `tr_to_bus`, `r_to_bus` and `ac_to_bus` is high. `drh_to_bus` is high only together with `tr_to_bus`. `mem_rd` and `mem_wr` are never high together.
- R10: `alu_sel` is 7'b0000100 (pass the bus to the accumulator) in the last cycle of opcode 0x01 and zero in every other cycle. `r_ld`, `z_ld` and `r_to_bus` stay low for all four opcodes.
- R11: The opcode and the zero flag are used only in the third fetch cycle. A zero flag that changes during the execute cycles does not alter the path already chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_val | input | 8 | Opcode presented by the instruction register |
| zero_flag | input | 1 | Accumulator-zero flag from the datapath |
| ar_inc | output | 1 | Increment address register |
| pc_inc | output | 1 | Increment program counter |
| ar_ld | output | 1 | Load address register |
| pc_ld | output | 1 | Load program counter |
| dr_ld | output | 1 | Load data register |
| tr_ld | output | 1 | Load temporary register |
| ir_ld | output | 1 | Load instruction register |
| r_ld | output | 1 | Load general register |
| ac_ld | output | 1 | Load accumulator |
| z_ld | output | 1 | Load zero flag |
| mem_to_bus | output | 1 | Memory drives the bus |
| bus_to_mem | output | 1 | Bus drives memory data-in |
| pc_to_bus | output | 1 | Program counter drives the bus |
| drh_to_bus | output | 1 | Data register drives the high address byte |
| drl_to_bus | output | 1 | Data register drives the low bus byte |
| tr_to_bus | output | 1 | Temporary register drives the bus |
| r_to_bus | output | 1 | General register drives the bus |
| ac_to_bus | output | 1 | Accumulator drives the bus |
| alu_sel | output | 7 | ALU function select |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
The assertions rely on two input conditions. The opcode and the zero flag must be settled in the third fetch cycle, since that is the only cycle whose next-state choice depends on them. Reset must be a clean level sampled on the clock. The stimulus changes `ir_val`, `zero_flag` and `rst_n` only on the falling clock edge. It sets the opcode and flag before each fetch begins. In one scenario it deliberately flips the zero flag after the decision cycle, to show that the flag is ignored there. One scenario also asserts reset midway through an execute sequence, to confirm the return to the first fetch state.

// File: rtl/acc_ctl_pkg.sv
// Package: shared state and opcode-class types for the accumulator control sequencer.
// Assumes: one state per control step; fetch states come first in the encoding.
package acc_ctl_pkg;

    // Control steps of the sequencer, one per clock cycle of an instruction.
    typedef enum logic [4:0] {
        S_F1, S_F2, S_F3,
        S_NOP1,
        S_LD1, S_LD2, S_LD3, S_LD4, S_LD5,
        S_ST1, S_ST2, S_ST3, S_ST4, S_ST5,
        S_JN1, S_JN2,
        S_JY1, S_JY2, S_JY3
    } step_t;

    // Opcode classes produced by the decoder.
    typedef enum logic [1:0] {
        C_NOP, C_LOAD, C_STORE, C_JZ
    } opcls_t;

    // Per-cycle control word (ALU select carried separately).
    typedef struct packed {
        logic ar_inc;
        logic pc_inc;
        logic ar_ld;
        logic pc_ld;
        logic dr_ld;
        logic tr_ld;
        logic ir_ld;
        logic r_ld;
        logic ac_ld;
        logic z_ld;
        logic mem_to_bus;
        logic bus_to_mem;
        logic pc_to_bus;
        logic drh_to_bus;
        logic drl_to_bus;
        logic tr_to_bus;
        logic r_to_bus;
        logic ac_to_bus;
        logic mem_rd;
        logic mem_wr;
    } ctl_word_t;

endpackage

// File: rtl/acc_ctl_opdec.sv
// Module: acc_ctl_opdec
// Classifies the opcode into one of the executable classes. The opcode table
// holds one entry per non-NOP class, in class order (load, store, jump).
// Any opcode that matches no entry is treated as a NOP.
// Assumes: the table entries are distinct.
module acc_ctl_opdec
    import acc_ctl_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter int N_OPS = 3,
    parameter logic [N_OPS*OPC_W-1:0] OP_TABLE = {8'h06, 8'h02, 8'h01}
) (
    input  logic [OPC_W-1:0] opcode,
    output opcls_t           cls
);

    logic [N_OPS-1:0] hit;

    // One comparator per table entry.
    genvar g;
    generate
        for (g = 0; g < N_OPS; g++) begin : g_match
            assign hit[g] = (opcode == OP_TABLE[g*OPC_W +: OPC_W]);
        end
    endgenerate

    // Map the match vector onto a class; no match falls back to NOP.
    always_comb begin
        cls = C_NOP;
        if (hit[0])      cls = C_LOAD;
        else if (hit[1]) cls = C_STORE;
        else if (hit[2]) cls = C_JZ;
    end

endmodule

// File: rtl/acc_ctl_seq.sv
// Module: acc_ctl_seq
// Holds the current control step and chooses the next one. The class and the
// zero flag are consulted only in the third fetch step; every other step has a
// fixed successor.
// Assumes: class and zero flag are stable in the third fetch step.
module acc_ctl_seq
    import acc_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  opcls_t cls,
    input  logic   zero_flag,
    output step_t  step
);

    step_t step_nxt;

    // Next-step selection: dispatch at the end of the fetch, fixed chain otherwise.
    always_comb begin
        step_nxt = S_F1;
        unique case (step)
            S_F1:   step_nxt = S_F2;
            S_F2:   step_nxt = S_F3;
            S_F3: begin
                unique case (cls)
                    C_LOAD:  step_nxt = S_LD1;
                    C_STORE: step_nxt = S_ST1;
                    C_JZ:    step_nxt = zero_flag ? S_JY1 : S_JN1;
                    default: step_nxt = S_NOP1;
                endcase
            end
            S_NOP1: step_nxt = S_F1;
            S_LD1:  step_nxt = S_LD2;
            S_LD2:  step_nxt = S_LD3;
            S_LD3:  step_nxt = S_LD4;
            S_LD4:  step_nxt = S_LD5;
            S_LD5:  step_nxt = S_F1;
            S_ST1:  step_nxt = S_ST2;
            S_ST2:  step_nxt = S_ST3;
            S_ST3:  step_nxt = S_ST4;
            S_ST4:  step_nxt = S_ST5;
            S_ST5:  step_nxt = S_F1;
            S_JN1:  step_nxt = S_JN2;
            S_JN2:  step_nxt = S_F1;
            S_JY1:  step_nxt = S_JY2;
            S_JY2:  step_nxt = S_JY3;
            S_JY3:  step_nxt = S_F1;
            default: step_nxt = S_F1;
        endcase
    end

    // Step register with synchronous active-low reset to the first fetch step.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= S_F1;
        else        step <= step_nxt;
    end

    // R1: a reset edge always lands in the first fetch step.
    p_reset_to_fetch_r1: assert property (@(posedge clk)
        !rst_n |=> step == S_F1);

    // R2: the fetch steps follow one another without a gap.
    p_fetch1_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step == S_F1 |=> step == S_F2);
    p_fetch2_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step == S_F2 |=> step == S_F3);

    // R3, R8: a NOP-class dispatch runs one idle step, then refetches.
    p_nop_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step == S_F3 && cls == C_NOP) |=> step == S_NOP1);
    p_nop_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step == S_NOP1 |=> step == S_F1);

    // R6: jump with the flag clear takes the short path.
    p_jump_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step == S_F3 && cls == C_JZ && !zero_flag) |=> step == S_JN1);

    // R7: jump with the flag set takes the target-load path.
    p_jump_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step == S_F3 && cls == C_JZ && zero_flag) |=> step == S_JY1);

    // R11: once inside the jump path, the flag no longer steers it.
    p_jump_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        step == S_JN1 |=> step == S_JN2);

endmodule

// File: rtl/acc_ctl_strobes.sv
// Module: acc_ctl_strobes
// Turns the current control step into the control word and ALU select (Moore
// decode). Steps that read a byte from memory share one pattern.
// Assumes: step is a legal encoding; clk and rst_n serve the checks only.
module acc_ctl_strobes
    import acc_ctl_pkg::*;
#(
    parameter int ALUS_W = 7,
    parameter logic [ALUS_W-1:0] ALUS_PASS = 7'b0000100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_t             step,
    output ctl_word_t         cw,
    output logic [ALUS_W-1:0] alu_sel
);

    // Strobe decode per step; anything not raised stays low.
    always_comb begin
        cw      = '0;
        alu_sel = '0;
        unique case (step)
            S_F1: begin
                cw.pc_to_bus = 1'b1;
                cw.ar_ld     = 1'b1;
            end
            S_F2: begin
                cw.mem_rd     = 1'b1;
                cw.mem_to_bus = 1'b1;
                cw.dr_ld      = 1'b1;
                cw.pc_inc     = 1'b1;
            end
            S_F3: begin
                cw.ir_ld     = 1'b1;
                cw.pc_to_bus = 1'b1;
                cw.ar_ld     = 1'b1;
            end
            S_LD1, S_ST1: begin
                cw.mem_rd     = 1'b1;
                cw.mem_to_bus = 1'b1;
                cw.dr_ld      = 1'b1;
                cw.pc_inc     = 1'b1;
                cw.ar_inc     = 1'b1;
            end
            S_LD2, S_ST2: begin
                cw.mem_rd     = 1'b1;
                cw.mem_to_bus = 1'b1;
                cw.dr_ld      = 1'b1;
                cw.tr_ld      = 1'b1;
                cw.pc_inc     = 1'b1;
            end
            S_LD3, S_ST3: begin
                cw.drh_to_bus = 1'b1;
                cw.tr_to_bus  = 1'b1;
                cw.ar_ld      = 1'b1;
            end
            S_LD4: begin
                cw.mem_rd     = 1'b1;
                cw.mem_to_bus = 1'b1;
                cw.dr_ld      = 1'b1;
            end
            S_LD5: begin
                cw.drl_to_bus = 1'b1;
                cw.ac_ld      = 1'b1;
                alu_sel       = ALUS_PASS;
            end
            S_ST4: begin
                cw.ac_to_bus = 1'b1;
                cw.dr_ld     = 1'b1;
            end
            S_ST5: begin
                cw.drl_to_bus = 1'b1;
                cw.bus_to_mem = 1'b1;
                cw.mem_wr     = 1'b1;
            end
            S_JN1, S_JN2: begin
                cw.pc_inc = 1'b1;
            end
            S_JY1: begin
                cw.mem_rd     = 1'b1;
                cw.mem_to_bus = 1'b1;
                cw.dr_ld      = 1'b1;
                cw.ar_inc     = 1'b1;
            end
            S_JY2: begin
                cw.mem_rd     = 1'b1;
                cw.mem_to_bus = 1'b1;
                cw.dr_ld      = 1'b1;
                cw.tr_ld      = 1'b1;
            end
            S_JY3: begin
                cw.drh_to_bus = 1'b1;
                cw.tr_to_bus  = 1'b1;
                cw.pc_ld      = 1'b1;
            end
            default: cw = '0;
        endcase
    end

    // R9: a single low-byte bus source per cycle.
    p_one_bus_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cw.mem_to_bus, cw.pc_to_bus, cw.drl_to_bus,
                    cw.tr_to_bus, cw.r_to_bus, cw.ac_to_bus}) <= 1);

    // R9: the high address byte is driven only as half of a 16-bit address.
    p_high_byte_paired_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cw.drh_to_bus |-> cw.tr_to_bus);

    // R9: no simultaneous memory read and write.
    p_rd_wr_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw.mem_rd && cw.mem_wr));

    // R10: a non-zero ALU select only ever feeds an accumulator load.
    p_alu_sel_with_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_sel != '0) |-> cw.ac_ld);

    // R10: the general register and zero flag are left alone.
    p_unused_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw.r_ld || cw.z_ld || cw.r_to_bus));

endmodule

// File: rtl/acc_ctl_top.sv
// Module: acc_ctl_top
// Control sequencer of a small 8-bit accumulator processor: opcode classifier,
// step register and strobe decode. Outputs depend only on the current step.
// Assumes: ir_val carries the incoming opcode and zero_flag is valid during
// the third fetch cycle.
module acc_ctl_top
    import acc_ctl_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter int ALUS_W = 7,
    parameter logic [OPC_W-1:0]  OP_LOAD  = 8'h01,
    parameter logic [OPC_W-1:0]  OP_STORE = 8'h02,
    parameter logic [OPC_W-1:0]  OP_JZ    = 8'h06,
    parameter logic [ALUS_W-1:0] ALUS_PASS = 7'b0000100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  ir_val,
    input  logic              zero_flag,
    output logic              ar_inc,
    output logic              pc_inc,
    output logic              ar_ld,
    output logic              pc_ld,
    output logic              dr_ld,
    output logic              tr_ld,
    output logic              ir_ld,
    output logic              r_ld,
    output logic              ac_ld,
    output logic              z_ld,
    output logic              mem_to_bus,
    output logic              bus_to_mem,
    output logic              pc_to_bus,
    output logic              drh_to_bus,
    output logic              drl_to_bus,
    output logic              tr_to_bus,
    output logic              r_to_bus,
    output logic              ac_to_bus,
    output logic [ALUS_W-1:0] alu_sel,
    output logic              mem_rd,
    output logic              mem_wr
);

    localparam int N_OPS = 3;
    localparam logic [N_OPS*OPC_W-1:0] OP_TABLE = {OP_JZ, OP_STORE, OP_LOAD};

    opcls_t    cls;
    step_t     step;
    ctl_word_t cw;

    acc_ctl_opdec #(
        .OPC_W    (OPC_W),
        .N_OPS    (N_OPS),
        .OP_TABLE (OP_TABLE)
    ) u_opdec (
        .opcode (ir_val),
        .cls    (cls)
    );

    acc_ctl_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls       (cls),
        .zero_flag (zero_flag),
        .step      (step)
    );

    acc_ctl_strobes #(
        .ALUS_W    (ALUS_W),
        .ALUS_PASS (ALUS_PASS)
    ) u_strobes (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .cw      (cw),
        .alu_sel (alu_sel)
    );

    // Fan the control word out to the individual strobe pins.
    assign ar_inc     = cw.ar_inc;
    assign pc_inc     = cw.pc_inc;
    assign ar_ld      = cw.ar_ld;
    assign pc_ld      = cw.pc_ld;
    assign dr_ld      = cw.dr_ld;
    assign tr_ld      = cw.tr_ld;
    assign ir_ld      = cw.ir_ld;
    assign r_ld       = cw.r_ld;
    assign ac_ld      = cw.ac_ld;
    assign z_ld       = cw.z_ld;
    assign mem_to_bus = cw.mem_to_bus;
    assign bus_to_mem = cw.bus_to_mem;
    assign pc_to_bus  = cw.pc_to_bus;
    assign drh_to_bus = cw.drh_to_bus;
    assign drl_to_bus = cw.drl_to_bus;
    assign tr_to_bus  = cw.tr_to_bus;
    assign r_to_bus   = cw.r_to_bus;
    assign ac_to_bus  = cw.ac_to_bus;
    assign mem_rd     = cw.mem_rd;
    assign mem_wr     = cw.mem_wr;

endmodule

// File: tb/tb_acc_ctl_top.sv
// Directed bench for acc_ctl_top: one task per scenario. Each task records an
// instruction's per-cycle outputs and compares them with values built here.
module tb_acc_ctl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ir_val = 8'h00;
    logic       zero_flag = 1'b0;
    logic ar_inc, pc_inc, ar_ld, pc_ld, dr_ld, tr_ld, ir_ld, r_ld, ac_ld, z_ld;
    logic mem_to_bus, bus_to_mem, pc_to_bus, drh_to_bus, drl_to_bus, tr_to_bus;
    logic r_to_bus, ac_to_bus, mem_rd, mem_wr;
    logic [6:0] alu_sel;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_ctl_top dut (
        .clk(clk), .rst_n(rst_n), .ir_val(ir_val), .zero_flag(zero_flag),
        .ar_inc(ar_inc), .pc_inc(pc_inc), .ar_ld(ar_ld), .pc_ld(pc_ld),
        .dr_ld(dr_ld), .tr_ld(tr_ld), .ir_ld(ir_ld), .r_ld(r_ld),
        .ac_ld(ac_ld), .z_ld(z_ld), .mem_to_bus(mem_to_bus),
        .bus_to_mem(bus_to_mem), .pc_to_bus(pc_to_bus),
        .drh_to_bus(drh_to_bus), .drl_to_bus(drl_to_bus),
        .tr_to_bus(tr_to_bus), .r_to_bus(r_to_bus), .ac_to_bus(ac_to_bus),
        .alu_sel(alu_sel), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    // Bit positions in the bench's packed view of the strobes.
    localparam int B_ARI = 19, B_PCI = 18, B_ARL = 17, B_PCL = 16, B_DRL = 15;
    localparam int B_TRL = 14, B_IRL = 13, B_RL = 12, B_ACL = 11, B_ZL = 10;
    localparam int B_MB = 9, B_BM = 8, B_PCB = 7, B_DHB = 6, B_DLB = 5;
    localparam int B_TRB = 4, B_RB = 3, B_ACB = 2, B_RD = 1, B_WR = 0;

    localparam logic [19:0] E_F1  = (20'd1 << B_PCB) | (20'd1 << B_ARL);
    localparam logic [19:0] E_RD  = (20'd1 << B_RD) | (20'd1 << B_MB) | (20'd1 << B_DRL);
    localparam logic [19:0] E_F2  = E_RD | (20'd1 << B_PCI);
    localparam logic [19:0] E_F3  = E_F1 | (20'd1 << B_IRL);
    localparam logic [19:0] E_A1  = E_RD | (20'd1 << B_PCI) | (20'd1 << B_ARI);
    localparam logic [19:0] E_A2  = E_RD | (20'd1 << B_TRL) | (20'd1 << B_PCI);
    localparam logic [19:0] E_A3  = (20'd1 << B_DHB) | (20'd1 << B_TRB) | (20'd1 << B_ARL);
    localparam logic [19:0] E_L5  = (20'd1 << B_DLB) | (20'd1 << B_ACL);
    localparam logic [19:0] E_S4  = (20'd1 << B_ACB) | (20'd1 << B_DRL);
    localparam logic [19:0] E_S5  = (20'd1 << B_DLB) | (20'd1 << B_BM) | (20'd1 << B_WR);
    localparam logic [19:0] E_JN  = (20'd1 << B_PCI);
    localparam logic [19:0] E_JY1 = E_RD | (20'd1 << B_ARI);
    localparam logic [19:0] E_JY2 = E_RD | (20'd1 << B_TRL);
    localparam logic [19:0] E_JY3 = (20'd1 << B_DHB) | (20'd1 << B_TRB) | (20'd1 << B_PCL);
    localparam logic [6:0]  ALU_PASS = 7'b0000100;

    logic [19:0] cw_now;
    assign cw_now = {ar_inc, pc_inc, ar_ld, pc_ld, dr_ld, tr_ld, ir_ld, r_ld,
                     ac_ld, z_ld, mem_to_bus, bus_to_mem, pc_to_bus, drh_to_bus,
                     drl_to_bus, tr_to_bus, r_to_bus, ac_to_bus, mem_rd, mem_wr};

    logic [19:0] tr_cw [0:15];
    logic [6:0]  tr_al [0:15];
    logic [19:0] ex_cw [0:15];
    int          tr_len;

    // Record one check result.
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Run one instruction from the first fetch cycle; flag switches to z_late from cycle 4.
    task automatic run_instr(input logic [7:0] op, input logic z_early, input logic z_late);
        ir_val = op;
        zero_flag = z_early;
        tr_len = 0;
        do begin
            if (tr_len == 3) zero_flag = z_late;
            tr_cw[tr_len] = cw_now;
            tr_al[tr_len] = alu_sel;
            tr_len++;
            @(negedge clk);
        end while (!(cw_now == E_F1) && tr_len < 16);
    endtask

    // Compare a recorded trace with the expected one, plus global rules.
    task automatic cmp_trace(input string req, input int exp_len, input bit is_load);
        int bus_bad = 0;
        int quiet_bad = 0;
        int alu_bad = 0;
        chk(req, "cycle count", tr_len, exp_len);
        for (int i = 0; i < exp_len && i < tr_len; i++) begin
            chk(req, $sformatf("strobes cycle %0d", i + 1), tr_cw[i], ex_cw[i]);
            if ($countones({tr_cw[i][B_MB], tr_cw[i][B_PCB], tr_cw[i][B_DLB],
                            tr_cw[i][B_TRB], tr_cw[i][B_RB], tr_cw[i][B_ACB]}) > 1
                || (tr_cw[i][B_DHB] && !tr_cw[i][B_TRB])
                || (tr_cw[i][B_RD] && tr_cw[i][B_WR])) bus_bad++;
            if (tr_cw[i][B_RL] || tr_cw[i][B_ZL] || tr_cw[i][B_RB]) quiet_bad++;
            if (tr_al[i] !== ((is_load && i == 7) ? ALU_PASS : 7'd0)) alu_bad++;
        end
        chk("R9", "bus/memory rule violations", bus_bad, 0);
        chk("R10", "unused strobes raised", quiet_bad, 0);
        chk("R10", "alu_sel mismatches", alu_bad, 0);
    endtask

    // Load the shared fetch prefix (R2) into the expected trace.
    task automatic exp_fetch();
        for (int i = 0; i < 16; i++) ex_cw[i] = '0;
        ex_cw[0] = E_F1;
        ex_cw[1] = E_F2;
        ex_cw[2] = E_F3;
    endtask

    // R1: held reset shows the first fetch cycle; release starts the fetch.
    task automatic t_reset();
        rst_n = 1'b0;
        ir_val = 8'h01;
        zero_flag = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", "strobes under reset", cw_now, E_F1);
            chk("R1", "alu_sel under reset", alu_sel, 7'd0);
        end
        rst_n = 1'b1;
    endtask

    // R3 and R2: plain NOP.
    task automatic t_nop();
        exp_fetch();
        run_instr(8'h00, 1'b0, 1'b0);
        cmp_trace("R3", 4, 1'b0);
    endtask

    // R4: load accumulator.
    task automatic t_load();
        exp_fetch();
        ex_cw[3] = E_A1; ex_cw[4] = E_A2; ex_cw[5] = E_A3;
        ex_cw[6] = E_RD; ex_cw[7] = E_L5;
        run_instr(8'h01, 1'b1, 1'b1);
        cmp_trace("R4", 8, 1'b1);
    endtask

    // R5: store accumulator.
    task automatic t_store();
        exp_fetch();
        ex_cw[3] = E_A1; ex_cw[4] = E_A2; ex_cw[5] = E_A3;
        ex_cw[6] = E_S4; ex_cw[7] = E_S5;
        run_instr(8'h02, 1'b0, 1'b0);
        cmp_trace("R5", 8, 1'b0);
    endtask

    // R6: jump not taken.
    task automatic t_jump_skip();
        exp_fetch();
        ex_cw[3] = E_JN; ex_cw[4] = E_JN;
        run_instr(8'h06, 1'b0, 1'b0);
        cmp_trace("R6", 5, 1'b0);
    endtask

    // R7: jump taken.
    task automatic t_jump_take();
        exp_fetch();
        ex_cw[3] = E_JY1; ex_cw[4] = E_JY2; ex_cw[5] = E_JY3;
        run_instr(8'h06, 1'b1, 1'b1);
        cmp_trace("R7", 6, 1'b0);
    endtask

    // R8: opcodes outside the decoded set behave as NOP.
    task automatic t_unknown();
        logic [7:0] ops [0:3];
        ops[0] = 8'h03; ops[1] = 8'h07; ops[2] = 8'h81; ops[3] = 8'hFF;
        for (int k = 0; k < 4; k++) begin
            exp_fetch();
            run_instr(ops[k], 1'b1, 1'b1);
            cmp_trace("R8", 4, 1'b0);
        end
    endtask

    // R11: a flag flip after the decision cycle does not change the path.
    task automatic t_late_flag();
        exp_fetch();
        ex_cw[3] = E_JN; ex_cw[4] = E_JN;
        run_instr(8'h06, 1'b0, 1'b1);
        cmp_trace("R11", 5, 1'b0);
        exp_fetch();
        ex_cw[3] = E_JY1; ex_cw[4] = E_JY2; ex_cw[5] = E_JY3;
        run_instr(8'h06, 1'b1, 1'b0);
        cmp_trace("R11", 6, 1'b0);
        zero_flag = 1'b0;
    endtask

    // R1: reset in the middle of an execute sequence returns to the fetch.
    task automatic t_reset_mid();
        ir_val = 8'h02;
        zero_flag = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk("R1", "store cycle 5 before reset", cw_now, E_A2);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "strobes after mid-run reset", cw_now, E_F1);
        rst_n = 1'b1;
        exp_fetch();
        run_instr(8'h00, 1'b0, 1'b0);
        cmp_trace("R1", 4, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        t_reset();
        t_nop();
        t_load();
        t_store();
        t_jump_skip();
        t_jump_take();
        t_unknown();
        t_late_flag();
        t_load();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule